// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank, x16 low-power SDRAM and walks the memory from power-on to a usable state. Once reset is released it keeps the command bus idle (NOP) with clock enable and the data masks high. It waits out a programmable stabilization interval, then issues a fixed series of one-cycle commands. The series is a precharge of all banks, a configurable number of auto-refresh commands, a write of the main mode register and a write of the extended (low-power) mode register. After the wait that follows the last command, it raises a ready flag.

Each wait time is given as a clock-cycle count parameter. For silicon, the stabilization count is the clock frequency times 200 µs; a simulation uses a small value instead. A single parameter picks whether the refresh group or the mode-register group runs first. The ready flag tells the downstream controller that normal traffic may begin.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, the bus shows NOP (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,1,1,1), `sd_cke` is 1, every `sd_dqm` bit is 1 and `init_done` is 0.
- R2: `sd_cke` and all `sd_dqm` bits stay 1 in every cycle after reset as well.
- R3: The first non-NOP command is precharge-all, which is pins 0,0,1,0 with `sd_addr[10]` = 1. It is shown right after the `STARTUP_CYC`-th rising clock edge following reset release, and the bus is NOP before that.
- R4: Exactly `N_REF` auto-refresh commands (pins 0,0,0,1) are issued.
- R5: The mode register write is pins 0,0,0,0 with `sd_ba` = 0 and `sd_addr` = `MODE_VAL`.
- R6: The extended mode register write directly follows the mode register write. It is pins 0,0,0,0 with `sd_ba` = 1 and `sd_addr` = `EXT_VAL` with bits 10:8 forced to 0.
- R7: With `REF_FIRST` = 1 the order is precharge, refreshes, mode, extended mode. With `REF_FIRST` = 0 it is precharge, mode, extended mode, refreshes.
- R8: The next command comes exactly `T_RP` edges after a precharge, `T_RC` edges after a refresh and `T_MRD` edges after either mode register write.
- R9: Every command lasts one cycle. Between commands, and after `init_done` rises, the bus is NOP.
- R10: `init_done` rises one full command spacing (per R8) after the last command and stays 1 until the next reset. A new reset restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, held high |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge) |
| sd_dqm | output | DQM_W | Data masks, held high |
| init_done | output | 1 | Ready flag, sticky until reset |

## Verification
The case hardest to reach from the ports is a reset that arrives after `init_done` is already high. The bench must show that the flag clears and that the whole timeline, including the long stabilization wait, replays cycle-exact. The stimulus runs one complete sequence, idles on the ready state, pulses reset again and compares a second full timeline. It does this on two instances that use opposite command orders and different refresh counts, against a schedule the bench derives from the spacing rules.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_PRE  = 3'd1,
    K_REF  = 3'd2,
    K_MRS  = 3'd3,
    K_EMRS = 3'd4
  } cmd_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  function automatic cmd_pins_t pins_of(cmd_kind_e k);
    case (k)
      K_PRE:          return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      K_REF:          return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      K_MRS, K_EMRS:  return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:        return '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  endfunction

  // Command issued at sequence position idx.
  function automatic cmd_kind_e kind_at(int unsigned idx, int unsigned nref, bit ref_first);
    if (idx == 0) return K_PRE;
    if (ref_first) begin
      if (idx <= nref)     return K_REF;
      if (idx == nref + 1) return K_MRS;
      return K_EMRS;
    end
    if (idx == 1) return K_MRS;
    if (idx == 2) return K_EMRS;
    return K_REF;
  endfunction

  // Edges from a command to the next one.
  function automatic int unsigned gap_of(cmd_kind_e k, int unsigned trp,
                                         int unsigned trc, int unsigned tmrd);
    case (k)
      K_PRE:   return trp;
      K_REF:   return trc;
      default: return tmrd;
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/init_wait_ctr.sv
module init_wait_ctr #(
  parameter int unsigned CW      = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= CW'(RST_VAL);
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/init_bus_drive.sv
module init_bus_drive
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned AP_BIT   = 10,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0,
  parameter logic [ADDR_W-1:0] EXT_VAL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  cmd_kind_e         kind,
  output cmd_pins_t         pins,
  output logic              ba,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] EXT_MASK = ADDR_W'({8{1'b1}});
  localparam logic [ADDR_W-1:0] AP_ONLY  = ADDR_W'(1) << AP_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins <= pins_of(K_NOP);
      ba   <= 1'b0;
      addr <= '0;
    end else if (issue) begin
      pins <= pins_of(kind);
      ba   <= (kind == K_EMRS);
      case (kind)
        K_PRE:   addr <= AP_ONLY;
        K_MRS:   addr <= MODE_VAL;
        K_EMRS:  addr <= EXT_VAL & EXT_MASK;
        default: addr <= '0;
      endcase
    end else begin
      pins <= pins_of(K_NOP);
      ba   <= 1'b0;
      addr <= '0;
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 40000,
  parameter int unsigned T_RP        = 4,
  parameter int unsigned T_RC        = 14,
  parameter int unsigned T_MRD       = 2,
  parameter int unsigned N_REF       = 2,
  parameter bit          REF_FIRST   = 1'b1,
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned AP_BIT      = 10,
  parameter int unsigned DQM_W       = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = 11'h032,
  parameter logic [ADDR_W-1:0] EXT_VAL  = 11'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_cke,
  output logic              sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);
  localparam int unsigned NSTEP  = 3 + N_REF;
  localparam int unsigned MAXCYC = max4(STARTUP_CYC, T_RP, T_RC, T_MRD);
  localparam int unsigned CW     = $clog2(MAXCYC + 1);
  localparam int unsigned SW     = $clog2(NSTEP + 1);

  logic [SW-1:0] step_q;
  logic          done_q;
  logic          wait_zero;
  logic          all_issued;
  logic          step_fire;
  logic          seq_finish;
  cmd_kind_e     kind_now;
  logic [CW-1:0] gap_ld;
  cmd_pins_t     bus_pins;

  assign all_issued = (int'(step_q) == NSTEP);
  assign step_fire  = wait_zero & ~done_q & ~all_issued;
  assign seq_finish = wait_zero & ~done_q & all_issued;

  always_comb begin
    kind_now = all_issued ? K_NOP : kind_at(int'(step_q), N_REF, REF_FIRST);
    gap_ld   = CW'(gap_of(kind_now, T_RP, T_RC, T_MRD) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (step_fire)  step_q <= step_q + 1'b1;
      if (seq_finish) done_q <= 1'b1;
    end
  end

  init_wait_ctr #(.CW(CW), .RST_VAL(STARTUP_CYC - 1)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step_fire),
    .load_val (gap_ld),
    .zero     (wait_zero)
  );

  init_bus_drive #(
    .ADDR_W   (ADDR_W),
    .AP_BIT   (AP_BIT),
    .MODE_VAL (MODE_VAL),
    .EXT_VAL  (EXT_VAL)
  ) u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (step_fire),
    .kind  (kind_now),
    .pins  (bus_pins),
    .ba    (sd_ba),
    .addr  (sd_addr)
  );

  assign sd_cs_n   = bus_pins.cs_n;
  assign sd_ras_n  = bus_pins.ras_n;
  assign sd_cas_n  = bus_pins.cas_n;
  assign sd_we_n   = bus_pins.we_n;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = '1;
  assign init_done = done_q;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned AP_BIT = 10,
  parameter int unsigned DQM_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic              sd_cke,
  input logic              sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done,
  input logic              step_fire,
  input logic              seq_finish
);
  logic [3:0] pins;
  logic       is_nop, is_pre, is_mode;
  assign pins    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_pre  = (pins == 4'b0010);
  assign is_mode = (pins == 4'b0000);

  p_cke_dqm_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke && (&sd_dqm));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_finish_raises_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> $rose(init_done));

  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

  p_fire_reaches_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> !is_nop);

  p_idle_means_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> is_nop);

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> sd_addr[AP_BIT]);

  p_ext_high_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mode && sd_ba) |-> (sd_addr[ADDR_W-1:8] == '0));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT),
  .DQM_W  (DQM_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sd_cs_n    (sd_cs_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .sd_we_n    (sd_we_n),
  .sd_cke     (sd_cke),
  .sd_ba      (sd_ba),
  .sd_addr    (sd_addr),
  .sd_dqm     (sd_dqm),
  .init_done  (init_done),
  .step_fire  (step_fire),
  .seq_finish (seq_finish)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int S   = 20;
  localparam int TRP = 3;
  localparam int TRC = 5;
  localparam int TMR = 2;
  localparam logic [10:0] MODEV = 11'h032;
  localparam logic [10:0] EXTV  = 11'h7A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_ba, a_done;
  logic [10:0] a_addr;
  logic [1:0]  a_dqm;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_ba, b_done;
  logic [10:0] b_addr;
  logic [1:0]  b_dqm;

  sdram_init_seq #(.STARTUP_CYC(S), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMR),
    .N_REF(2), .REF_FIRST(1'b1), .MODE_VAL(MODEV), .EXT_VAL(EXTV)) dut (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(a_cs), .sd_ras_n(a_ras), .sd_cas_n(a_cas),
    .sd_we_n(a_we), .sd_cke(a_cke), .sd_ba(a_ba), .sd_addr(a_addr),
    .sd_dqm(a_dqm), .init_done(a_done));

  sdram_init_seq #(.STARTUP_CYC(S), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMR),
    .N_REF(3), .REF_FIRST(1'b0), .MODE_VAL(MODEV), .EXT_VAL(EXTV)) dut_b (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(b_cs), .sd_ras_n(b_ras), .sd_cas_n(b_cas),
    .sd_we_n(b_we), .sd_cke(b_cke), .sd_ba(b_ba), .sd_addr(b_addr),
    .sd_dqm(b_dqm), .init_done(b_done));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // 0 nop, 1 precharge, 2 refresh, 3 mode, 4 extended mode
  function automatic int step_kind(int i, int nref, bit rf);
    if (i == 0) return 1;
    if (rf) return (i <= nref) ? 2 : ((i == nref + 1) ? 3 : 4);
    return (i == 1) ? 3 : ((i == 2) ? 4 : 2);
  endfunction

  function automatic int spacing(int k);
    return (k == 1) ? TRP : ((k == 2) ? TRC : TMR);
  endfunction

  // Kind expected after edge e; -1 means done region
  function automatic int exp_kind(int e, int nref, bit rf);
    int t = S;
    for (int i = 0; i < nref + 3; i++) begin
      if (e == t) return step_kind(i, nref, rf);
      t += spacing(step_kind(i, nref, rf));
    end
    return (e >= t) ? -1 : 0;
  endfunction

  function automatic logic [3:0] exp_pins(int k);
    case (k)
      1: return 4'b0010;
      2: return 4'b0001;
      3, 4: return 4'b0000;
      default: return 4'b0111;
    endcase
  endfunction

  task automatic check_one(int e, int nref, bit rf, logic [3:0] pins, logic cke,
                           logic [1:0] dqm, logic ba, logic [10:0] addr, logic done,
                           ref int nrefs);
    int k = exp_kind(e, nref, rf);
    int kk = (k < 0) ? 0 : k;
    chk(cke && (&dqm), "R2 cke/dqm high", {cke, dqm}, 3'b111);
    if (kk == 1) chk(pins == 4'b0010 && addr[10], "R3 precharge-all", {pins, addr}, {4'b0010, 11'h400});
    else if (kk == 2) begin
      chk(pins == 4'b0001, rf ? "R4 refresh (R7 order)" : "R4 refresh (R7 mode-first)", pins, 4'b0001);
      nrefs++;
    end
    else if (kk == 3) chk(pins == 4'b0000 && !ba && addr == MODEV, "R5 mode write",
                          {pins, ba, addr}, {4'b0000, 1'b0, MODEV});
    else if (kk == 4) chk(pins == 4'b0000 && ba && addr == (EXTV & 11'h0FF), "R6 ext mode write",
                          {pins, ba, addr}, {4'b0000, 1'b1, EXTV & 11'h0FF});
    else chk(pins == exp_pins(0), "R9 nop between/after", pins, 4'b0111);
    if (e < S && pins != 4'b0111) chk(1'b0, "R3 nop before startup", pins, 4'b0111);
    chk(done == (k < 0), "R10 done timing", done, (k < 0));
    if (k > 0) chk(pins == exp_pins(k), "R8 spacing", pins, exp_pins(k));
  endtask

  task automatic check_reset();
    chk({a_cs, a_ras, a_cas, a_we} == 4'b0111 && a_cke && (&a_dqm) && !a_done,
        "R1 reset state A", {a_cs, a_ras, a_cas, a_we, a_cke, a_dqm, a_done}, 8'b01111110);
    chk({b_cs, b_ras, b_cas, b_we} == 4'b0111 && b_cke && (&b_dqm) && !b_done,
        "R1 reset state B", {b_cs, b_ras, b_cas, b_we, b_cke, b_dqm, b_done}, 8'b01111110);
  endtask

  task automatic run_seq(int cycles);
    int ra = 0;
    int rb = 0;
    for (int e = 1; e <= cycles; e++) begin
      @(posedge clk);
      @(negedge clk);
      check_one(e, 2, 1'b1, {a_cs, a_ras, a_cas, a_we}, a_cke, a_dqm, a_ba, a_addr, a_done, ra);
      check_one(e, 3, 1'b0, {b_cs, b_ras, b_cas, b_we}, b_cke, b_dqm, b_ba, b_addr, b_done, rb);
    end
    chk(ra == 2, "R4 refresh count A", ra, 2);
    chk(rb == 3, "R4 refresh count B", rb, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    run_seq(70);
    // reset after ready: flag clears and sequence replays
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset();
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    run_seq(70);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule